// File: doc/BRIEF.md
# Code-Selected Reference Divider

This block divides a reference clock by one of eight fixed ratios and emits a one-clock pulse once per division period. The pulse marks the reference phase for a downstream phase comparator. A 3-bit select code, held on static parallel lines, picks the ratio. A small lookup turns the code into a 14-bit terminal count, and a down-counter reloads from that count each period. Seven of the eight ratios are powers of two. The eighth is 2410, which a plain power-of-two prescaler cannot produce.

The select code is read only when the counter reloads. A code change therefore never cuts a period short and never merges two periods. When the select lines are left undriven they are treated as all ones, which is code 111 and divide-by-8192. The reset input is asserted asynchronously and released synchronously inside the block. The output stays low until the first terminal count after reset.

Top module: `refdiv_top`

## Requirements
- R1: The select code maps to these divide ratios: code 0 gives 8, code 1 gives 128, code 2 gives 256, code 3 gives 512, code 4 gives 1024, code 5 gives 2048, code 6 gives 2410 and code 7 gives 8192. Code bit 0 is `ratio_sel[0]`.
- R2: With a steady code whose ratio is R, `ref_pulse` is high for exactly one clock cycle, and consecutive rising edges of `ref_pulse` are exactly R clock cycles apart.
- R3: The period counter is 14 bits wide and never holds a value above 8191, which is the largest ratio minus one.
- R4: A code change made in the middle of a period leaves that period at the old ratio. The next period uses the new ratio.
- R5: While `rst_n` is low, `ref_pulse` is low. After `rst_n` rises between two clock edges, the first pulse is high after the (R+3)-th rising clock edge, where R is the ratio of the code held during that time. Two of those cycles are the reset release stages.
- R6: The all-ones code, which stands for undriven select lines, gives a pulse spacing of 8192 cycles.
- R7: A code change that is made and undone before the next reload has no effect on the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| ratio_sel | input | 3 | Static divide-ratio select code |
| ref_pulse | output | 1 | One-cycle pulse at the divided rate |

## Verification
The bench measures the pulse spacing for every code, including 2410. An off-by-one reload would show up there as a period of R-1 or R+1, and a wrong table entry as the wrong spacing for one code. It changes the code in the middle of a period. A design that sampled the code continuously would produce a short or stretched period at that point instead of finishing the old one. It also pulses the code briefly and then restores it, which catches a divider that latches transient codes. Last, it checks the first-pulse latency after reset, which exposes a counter that starts from zero or from the wrong code's count.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CNT_W = 14;
  localparam int SEL_W = 3;
  localparam int NUM_RATIOS = 1 << SEL_W;

  // Divide ratio for each select code.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd0:    r = 14'd8;
      3'd1:    r = 14'd128;
      3'd2:    r = 14'd256;
      3'd3:    r = 14'd512;
      3'd4:    r = 14'd1024;
      3'd5:    r = 14'd2048;
      3'd6:    r = 14'd2410;
      default: r = 14'd8192;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/refdiv_ratio_rom.sv
module refdiv_ratio_rom
  import refdiv_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  reload
);
  localparam int ENTRIES = 1 << SW;
  logic [W-1:0] table_m1 [ENTRIES];

  // Each entry holds ratio - 1, the value the down-counter starts from.
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
    assign table_m1[gi] = W'(ratio_of(SW'(gi))) - W'(1);
  end

  always_comb begin
    reload = table_m1[sel];
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         armed,
  output logic         pulse
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         arm_q, arm_d;
  logic         pulse_q, pulse_d;
  logic         cnt_en;

  assign cnt_en = 1'b1;

  // Next state: load on the first active cycle, reload at zero, else count down.
  always_comb begin
    cnt_d   = cnt_q;
    arm_d   = arm_q;
    pulse_d = 1'b0;
    if (!arm_q) begin
      cnt_d = reload;
      arm_d = 1'b1;
    end else if (cnt_q == '0) begin
      cnt_d   = reload;
      pulse_d = 1'b1;
    end else begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q   <= '0;
      arm_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      arm_q   <= arm_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt   = cnt_q;
  assign armed = arm_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             ref_pulse
);
  logic             rst_s;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             armed;

  refdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  refdiv_ratio_rom #(.W(CNT_W), .SW(SEL_W)) u_rom (
    .sel    (ratio_sel),
    .reload (reload)
  );

  refdiv_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_s  (rst_s),
    .reload (reload),
    .cnt    (cnt),
    .armed  (armed),
    .pulse  (ref_pulse)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_s,
  input logic [SEL_W-1:0] ratio_sel,
  input logic             ref_pulse,
  input logic [CNT_W-1:0] cnt,
  input logic             armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = 14'd8191;

  assert_single_cycle_pulse_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ref_pulse |=> !ref_pulse);

  assert_countdown_step_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && $past(armed) && !ref_pulse) |-> (cnt == $past(cnt) - 14'd1));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_s)
    cnt <= CNT_MAX);

  assert_reload_from_code_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ref_pulse |-> (cnt == ratio_of($past(ratio_sel)) - 14'd1));

  assert_no_pulse_before_arm_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(armed) |-> !ref_pulse);
endmodule

bind refdiv_top refdiv_checker u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .ratio_sel (ratio_sel),
  .ref_pulse (ref_pulse),
  .cnt       (cnt),
  .armed     (armed)
);

// File: tb/tb_refdiv_top.sv
`timescale 1ns/1ps
module tb_refdiv_top;
  logic       clk;
  logic       rst_n;
  logic [2:0] ratio_sel;
  logic       ref_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam int VRATIO [8] = '{8, 128, 256, 512, 1024, 2048, 2410, 8192};

  refdiv_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .ref_pulse (ref_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count falling edges until the pulse is seen high at a falling edge.
  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ref_pulse && n < 20000);
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst_n     = 1'b0;
    ratio_sel = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int n2;
    rst_n     = 1'b0;
    ratio_sel = 3'b111;

    // R5: output low during reset
    repeat (4) begin
      @(negedge clk);
      check("R5 low in reset", int'(ref_pulse), 0);
    end

    // Table walk: R1 spacing per code, R2 width, R5 first-pulse latency
    for (int i = 0; i < 8; i++) begin
      do_reset(3'(i));
      count_to_pulse(n);
      check($sformatf("R5 first pulse code %0d", i), n, VRATIO[i] + 3);
      count_to_pulse(n);
      check($sformatf("R1 spacing code %0d", i), n, VRATIO[i]);
      @(negedge clk);
      check($sformatf("R2 width code %0d", i), int'(ref_pulse), 0);
      count_to_pulse(n);
      check($sformatf("R2 spacing code %0d", i), n, VRATIO[i] - 1);
    end

    // R6: all-ones default code gives 8192
    do_reset(3'b111);
    count_to_pulse(n);
    count_to_pulse(n);
    check("R6 default code spacing", n, 8192);

    // R4: change 8192 -> 8 in mid-period
    count_to_pulse(n);
    repeat (1000) @(negedge clk);
    ratio_sel = 3'd0;
    count_to_pulse(n);
    check("R4 old period kept", n + 1000, 8192);
    count_to_pulse(n);
    check("R4 new period used", n, 8);

    // R4: change 8 -> 2410 in mid-period
    repeat (3) @(negedge clk);
    ratio_sel = 3'd6;
    count_to_pulse(n);
    check("R4 short old period kept", n + 3, 8);
    count_to_pulse(n);
    check("R4 2410 period used", n, 2410);

    // R7: brief code glitch does not change spacing
    ratio_sel = 3'd3;
    count_to_pulse(n);
    count_to_pulse(n);
    repeat (100) @(negedge clk);
    ratio_sel = 3'd0;
    @(negedge clk);
    ratio_sel = 3'd3;
    count_to_pulse(n2);
    check("R7 glitch period", n2 + 101, 512);
    count_to_pulse(n);
    check("R7 following period", n, 512);

    // R3: largest count 8191 reached without overflow; spacing stays 8192 twice
    ratio_sel = 3'd7;
    count_to_pulse(n);
    count_to_pulse(n);
    check("R3 max count period", n, 8192);

    // R5: asynchronous reset drops the pulse and restarts the count
    ratio_sel = 3'd0;
    count_to_pulse(n);
    count_to_pulse(n);
    #1 rst_n = 1'b0;
    #1 check("R5 async reset clears pulse", int'(ref_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_to_pulse(n);
    check("R5 restart latency", n, 8 + 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule